// File: doc/BRIEF.md
# Receive Character Queue with Error Status and RTS Pacing

This block sits between a serial receiver and the CPU. Each received character enters a small first-in first-out queue together with three error flags: framing error, parity error and break. The CPU sees the oldest character and takes it with a pop strobe. The three error status outputs work in one of two styles, chosen by a mode input. In per-character style they show the flags of the oldest stored character. In accumulated style they show the OR of the flags of every character that has become the oldest since the last error-clear command.

The block also drives an active-low request-to-send output (`rts_n`). Two commands assert and negate it by hand. When automatic pacing is on and the line is asserted, a start-bit strobe that arrives while the queue is full negates the line. The line is asserted again once a slot is free. A character offered while the queue is full is dropped and sets a sticky overrun flag. The interrupt request follows either the "character available" indication or the "queue full" indication.

The request-to-send control is a three-state machine:
- `RTS_IDLE`: line negated by command or by reset.
- `RTS_LIVE`: line asserted.
- `RTS_PAUSE`: line negated automatically, waiting for space.

Its transitions are:
- any → `RTS_IDLE` on the negate command, which has top priority.
- any → `RTS_LIVE` on the assert command.
- `RTS_LIVE` → `RTS_PAUSE` on a start bit while full with pacing enabled.
- `RTS_PAUSE` → `RTS_LIVE` when the queue is no longer full.

Top module: `rx_fifo_status`

## Requirements
- R1: After reset the queue is empty: `rx_ready`=0, `fifo_full`=0, `overrun`=0, `irq`=0, all three status bits are 0 and `rts_n`=1.
- R2: Characters leave in arrival order. `head_data` shows the oldest stored character, and a pop on an empty queue has no effect.
- R3: `fifo_full`=1 when DEPTH (default 3) characters are stored. A push while full without a pop in the same cycle is discarded, leaves the stored characters unchanged and sets `overrun`.
- R4: With `err_mode`=0 (per-character), `stat_fe`/`stat_pe`/`stat_brk` equal the flags of the oldest stored character, and all are 0 when the queue is empty.
- R5: With `err_mode`=1 (accumulated), each status bit is the OR of that flag over all characters that became oldest since the last `reset_err`. A character becomes oldest either on a push into an empty queue or when a pop exposes it.
- R6: `reset_err` clears the accumulated flags and `overrun`. If a character becomes oldest in the same cycle, its flags are the only ones kept.
- R7: `irq` follows `rx_ready` when `irq_sel`=0 and follows `fifo_full` when `irq_sel`=1.
- R8: `rts_off_cmd` negates `rts_n` (1) in the next cycle, with priority over all else. `rts_on_cmd` alone asserts it (0) in the next cycle.
- R9: With `auto_rts_en`=1 and `rts_n`=0, a `start_bit` while `fifo_full`=1 drives `rts_n` to 1 in the next cycle. No negation happens if the queue is not full or pacing is off.
- R10: After an automatic negation, `rts_n` returns to 0 one cycle after `fifo_full` drops. A negate command during the pause keeps it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Receiver delivers a character |
| push_data | input | DW | Received character |
| push_fe | input | 1 | Framing error flag of the character |
| push_pe | input | 1 | Parity error flag of the character |
| push_brk | input | 1 | Break flag of the character |
| start_bit | input | 1 | Receiver detected a valid start bit |
| pop | input | 1 | CPU takes the oldest character |
| reset_err | input | 1 | Error-clear command |
| err_mode | input | 1 | 0 per-character status, 1 accumulated status |
| irq_sel | input | 1 | 0 interrupt on character available, 1 on queue full |
| auto_rts_en | input | 1 | Enable automatic RTS negation |
| rts_on_cmd | input | 1 | Command: assert RTS |
| rts_off_cmd | input | 1 | Command: negate RTS |
| head_data | output | DW | Oldest stored character |
| rx_ready | output | 1 | At least one character stored |
| fifo_full | output | 1 | Queue holds DEPTH characters |
| stat_fe | output | 1 | Framing error status |
| stat_pe | output | 1 | Parity error status |
| stat_brk | output | 1 | Break status |
| overrun | output | 1 | Sticky: a character was dropped |
| irq | output | 1 | Receiver interrupt request |
| rts_n | output | 1 | Request to send, active low |

## Verification
A push or pop changes `head_data`, `rx_ready`, `fifo_full`, `overrun`, the status bits and `irq` right after the clock edge that takes it, so there is no extra latency. The bench drives each stimulus for one edge and samples one time unit after that edge. `rts_n` also changes right after the edge that takes a command or start bit. The one exception is the return from a pause: `rts_n` falls one edge after `fifo_full` falls. The bench checks `rts_n` still high after the pop edge and low after the following edge.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef struct packed {
        logic brk;
        logic pe;
        logic fe;
    } rx_flags_t;

    typedef enum logic [1:0] {
        RTS_IDLE  = 2'd0,
        RTS_LIVE  = 2'd1,
        RTS_PAUSE = 2'd2
    } rts_state_t;
endpackage

// File: rtl/rxs_store.sv
module rxs_store
    import rxs_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  rx_flags_t       wr_flags,
    input  logic            rd_en,
    output logic            wr_ok,
    output logic            rd_ok,
    output logic [DW-1:0]   head_data,
    output rx_flags_t       head_flags,
    output rx_flags_t       nxt_flags,
    output logic            empty,
    output logic            full,
    output logic            multi
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = DW + 3;

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr, rd_inc;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign multi  = (count > CW'(1));
    assign rd_ok  = rd_en && !empty;
    assign wr_ok  = wr_en && (!full || rd_ok);
    assign rd_inc = bump(rd_ptr);

    assign head_data  = mem[rd_ptr][DW-1:0];
    assign head_flags = rx_flags_t'(mem[rd_ptr][EW-1:DW]);
    assign nxt_flags  = rx_flags_t'(mem[rd_inc][EW-1:DW]);

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= {wr_flags, wr_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= rd_inc;
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxs_errstat.sv
module rxs_errstat
    import rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      err_mode,
    input  logic      reset_err,
    input  logic      head_valid,
    input  rx_flags_t head_flags,
    input  logic      new_head,
    input  rx_flags_t new_flags,
    output rx_flags_t status
);
    rx_flags_t acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= (reset_err ? rx_flags_t'('0) : acc)
                 | (new_head ? new_flags : rx_flags_t'('0));
        end
    end

    always_comb begin
        if (err_mode)        status = acc;
        else if (head_valid) status = head_flags;
        else                 status = '0;
    end
endmodule

// File: rtl/rxs_rts_fsm.sv
module rxs_rts_fsm
    import rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic on_cmd,
    input  logic off_cmd,
    input  logic start_bit,
    input  logic full,
    output logic rts_n
);
    rts_state_t state, next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_IDLE;
        else        state <= next;
    end

    always_comb begin
        next = state;
        if (off_cmd) begin
            next = RTS_IDLE;
        end else if (on_cmd) begin
            next = RTS_LIVE;
        end else begin
            unique case (state)
                RTS_IDLE:  next = RTS_IDLE;
                RTS_LIVE:  if (auto_en && start_bit && full) next = RTS_PAUSE;
                RTS_PAUSE: if (!full) next = RTS_LIVE;
                default:   next = RTS_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            RTS_LIVE: rts_n = 1'b0;
            default:  rts_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
    import rxs_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          push_fe,
    input  logic          push_pe,
    input  logic          push_brk,
    input  logic          start_bit,
    input  logic          pop,
    input  logic          reset_err,
    input  logic          err_mode,
    input  logic          irq_sel,
    input  logic          auto_rts_en,
    input  logic          rts_on_cmd,
    input  logic          rts_off_cmd,
    output logic [DW-1:0] head_data,
    output logic          rx_ready,
    output logic          fifo_full,
    output logic          stat_fe,
    output logic          stat_pe,
    output logic          stat_brk,
    output logic          overrun,
    output logic          irq,
    output logic          rts_n
);
    rx_flags_t in_flags, head_flags, nxt_flags, new_flags, status;
    logic wr_ok, rd_ok, empty, full, multi, new_head, ovr_q;

    assign in_flags = '{brk: push_brk, pe: push_pe, fe: push_fe};

    rxs_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push_valid), .wr_data(push_data), .wr_flags(in_flags),
        .rd_en(pop), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .head_data(head_data), .head_flags(head_flags), .nxt_flags(nxt_flags),
        .empty(empty), .full(full), .multi(multi)
    );

    always_comb begin
        new_head  = 1'b0;
        new_flags = in_flags;
        if (empty) begin
            new_head = wr_ok;
        end else if (rd_ok) begin
            if (multi) begin
                new_head  = 1'b1;
                new_flags = nxt_flags;
            end else begin
                new_head = wr_ok;
            end
        end
    end

    rxs_errstat u_err (
        .clk(clk), .rst_n(rst_n), .err_mode(err_mode), .reset_err(reset_err),
        .head_valid(!empty), .head_flags(head_flags),
        .new_head(new_head), .new_flags(new_flags), .status(status)
    );

    rxs_rts_fsm u_rts (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en),
        .on_cmd(rts_on_cmd), .off_cmd(rts_off_cmd),
        .start_bit(start_bit), .full(full), .rts_n(rts_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ovr_q <= 1'b0;
        else if (reset_err)              ovr_q <= 1'b0;
        else if (push_valid && !wr_ok)   ovr_q <= 1'b1;
    end

    assign rx_ready  = !empty;
    assign fifo_full = full;
    assign stat_fe   = status.fe;
    assign stat_pe   = status.pe;
    assign stat_brk  = status.brk;
    assign overrun   = ovr_q;
    assign irq       = irq_sel ? full : !empty;
endmodule

// File: rtl/rx_fifo_status_chk.sv
module rx_fifo_status_chk (
    input logic clk,
    input logic rst_n,
    input logic push_valid,
    input logic pop,
    input logic reset_err,
    input logic err_mode,
    input logic start_bit,
    input logic auto_rts_en,
    input logic rts_on_cmd,
    input logic rts_off_cmd,
    input logic rx_ready,
    input logic fifo_full,
    input logic stat_fe,
    input logic stat_pe,
    input logic stat_brk,
    input logic overrun,
    input logic rts_n
);
    p_full_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> rx_ready);

    p_drop_sets_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && fifo_full && !pop && !reset_err) |=> overrun);

    p_empty_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !err_mode) |-> !(stat_fe || stat_pe || stat_brk));

    p_clear_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_err |=> !overrun);

    p_manual_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rts_off_cmd |=> rts_n);

    p_manual_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_on_cmd && !rts_off_cmd) |=> !rts_n);

    p_auto_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && !rts_n && start_bit && fifo_full && !rts_on_cmd) |=> rts_n);
endmodule

bind rx_fifo_status rx_fifo_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop(pop),
    .reset_err(reset_err), .err_mode(err_mode), .start_bit(start_bit),
    .auto_rts_en(auto_rts_en), .rts_on_cmd(rts_on_cmd), .rts_off_cmd(rts_off_cmd),
    .rx_ready(rx_ready), .fifo_full(fifo_full), .stat_fe(stat_fe),
    .stat_pe(stat_pe), .stat_brk(stat_brk), .overrun(overrun), .rts_n(rts_n)
);

// File: tb/rx_fifo_status_test.sv
`timescale 1ns/1ps
module rx_fifo_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 0, push_fe = 0, push_pe = 0, push_brk = 0;
    logic [7:0] push_data = '0;
    logic start_bit = 0, pop = 0, reset_err = 0, err_mode = 0, irq_sel = 0;
    logic auto_rts_en = 0, rts_on_cmd = 0, rts_off_cmd = 0;
    logic [7:0] head_data;
    logic rx_ready, fifo_full, stat_fe, stat_pe, stat_brk, overrun, irq, rts_n;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    rx_fifo_status #(.DW(8), .DEPTH(3)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic do_push(input logic [7:0] d, input logic fe, input logic pe, input logic brk);
        push_valid = 1; push_data = d; push_fe = fe; push_pe = pe; push_brk = brk;
        cyc();
        push_valid = 0; push_fe = 0; push_pe = 0; push_brk = 0;
    endtask

    task automatic do_pop();
        pop = 1; cyc(); pop = 0;
    endtask

    task automatic t_reset();
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 fifo_full", fifo_full, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 irq", irq, 0);
        chk("R1 status", {stat_fe, stat_pe, stat_brk}, 0);
        chk("R1 rts_n", rts_n, 1);
    endtask

    task automatic t_order();
        do_push(8'hA1, 0, 0, 0);
        do_push(8'hB2, 0, 0, 0);
        chk("R2 head first", head_data, 8'hA1);
        do_pop();
        chk("R2 head second", head_data, 8'hB2);
        do_pop();
        chk("R2 drained", rx_ready, 0);
        do_pop();
        chk("R2 pop empty ignored", rx_ready, 0);
        do_push(8'hC3, 0, 0, 0);
        chk("R2 head after empty pop", head_data, 8'hC3);
        chk("R2 one entry only", fifo_full, 0);
        do_pop();
    endtask

    task automatic t_full();
        irq_sel = 0;
        do_push(8'h11, 0, 0, 0);
        chk("R7 irq on ready", irq, 1);
        irq_sel = 1; #1;
        chk("R7 irq not full", irq, 0);
        do_push(8'h22, 0, 0, 0);
        do_push(8'h33, 0, 0, 0);
        chk("R3 full", fifo_full, 1);
        chk("R7 irq on full", irq, 1);
        chk("R3 no overrun yet", overrun, 0);
        do_push(8'h44, 0, 0, 0);
        chk("R3 overrun set", overrun, 1);
        chk("R3 head kept", head_data, 8'h11);
        do_pop();
        chk("R3 second kept", head_data, 8'h22);
        do_pop();
        chk("R3 third kept", head_data, 8'h33);
        do_pop();
        chk("R3 dropped char absent", rx_ready, 0);
        reset_err = 1; cyc(); reset_err = 0;
        chk("R6 overrun cleared", overrun, 0);
        irq_sel = 0;
    endtask

    task automatic t_char();
        err_mode = 0;
        do_push(8'h01, 1, 0, 0);
        do_push(8'h02, 0, 1, 0);
        chk("R4 head fe", {stat_fe, stat_pe, stat_brk}, 3'b100);
        do_pop();
        chk("R4 head pe", {stat_fe, stat_pe, stat_brk}, 3'b010);
        do_pop();
        chk("R4 empty clean", {stat_fe, stat_pe, stat_brk}, 3'b000);
    endtask

    task automatic t_block();
        err_mode = 1;
        reset_err = 1; cyc(); reset_err = 0;
        do_push(8'h05, 1, 0, 0);
        do_push(8'h06, 0, 1, 0);
        do_push(8'h07, 0, 0, 0);
        chk("R5 only head counted", {stat_fe, stat_pe, stat_brk}, 3'b100);
        do_pop();
        chk("R5 accumulate", {stat_fe, stat_pe, stat_brk}, 3'b110);
        do_pop();
        chk("R5 sticky over clean", {stat_fe, stat_pe, stat_brk}, 3'b110);
        reset_err = 1; cyc(); reset_err = 0;
        chk("R6 clear acc", {stat_fe, stat_pe, stat_brk}, 3'b000);
        do_push(8'h08, 0, 0, 1);
        chk("R5 non-head ignored", {stat_fe, stat_pe, stat_brk}, 3'b000);
        pop = 1; reset_err = 1; cyc(); pop = 0; reset_err = 0;
        chk("R6 same-cycle head kept", {stat_fe, stat_pe, stat_brk}, 3'b001);
        do_pop();
        reset_err = 1; cyc(); reset_err = 0;
        err_mode = 0;
    endtask

    task automatic t_rts();
        auto_rts_en = 1;
        rts_on_cmd = 1; cyc(); rts_on_cmd = 0;
        chk("R8 manual on", rts_n, 0);
        start_bit = 1; cyc(); start_bit = 0;
        chk("R9 no drop when not full", rts_n, 0);
        do_push(8'h31, 0, 0, 0);
        do_push(8'h32, 0, 0, 0);
        do_push(8'h33, 0, 0, 0);
        start_bit = 1; cyc(); start_bit = 0;
        chk("R9 auto drop", rts_n, 1);
        cyc();
        chk("R10 held while full", rts_n, 1);
        do_pop();
        chk("R10 not yet back", rts_n, 1);
        cyc();
        chk("R10 reasserted", rts_n, 0);
        do_push(8'h34, 0, 0, 0);
        auto_rts_en = 0;
        start_bit = 1; cyc(); start_bit = 0;
        chk("R9 no drop when auto off", rts_n, 0);
        auto_rts_en = 1;
        start_bit = 1; cyc(); start_bit = 0;
        chk("R9 drop again", rts_n, 1);
        rts_off_cmd = 1; cyc(); rts_off_cmd = 0;
        do_pop();
        cyc();
        chk("R10 off during pause stays off", rts_n, 1);
        rts_on_cmd = 1; rts_off_cmd = 1; cyc(); rts_on_cmd = 0; rts_off_cmd = 0;
        chk("R8 off wins", rts_n, 1);
        rts_on_cmd = 1; cyc(); rts_on_cmd = 0;
        rts_off_cmd = 1; cyc(); rts_off_cmd = 0;
        chk("R8 manual off", rts_n, 1);
        do_pop(); do_pop();
        auto_rts_en = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cyc();
        t_reset();
        t_order();
        t_full();
        t_char();
        t_block();
        t_rts();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule